// File: doc/BRIEF.md
# Pixel Row Zero-Suppression Encoder

This block turns one row of binary pixel discriminator outputs into a short list of hit descriptors. A row enters as a full bit vector with its row index, through a valid/ready handshake. The encoder walks the row one column per clock. It finds runs of adjacent fired pixels and cuts each run into pieces of at most four pixels. Each piece becomes a state that holds its start column and its length.

The row is split into fixed-width banks, and a run never continues across a bank edge. Two hard caps apply: one on the states kept in a single bank and one on the states kept in the whole row. A state that exceeds either cap is thrown away. The output stream is never stalled to make room for it. Instead, the row header marks the loss.

For a row with at least one fired pixel, the block sends a header word and then the kept states, over a valid/ready word stream. A row with no fired pixel produces no words at all. A new row is taken only after every word of the previous row has been handed off.

Top module: `zs_row_encoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1, and no word is pending.
- R2: A row whose pixels are all 0 produces no output word, and in_ready returns to 1 afterwards.
- R3: A row with a fired pixel produces a header word before its states. In the header, bit WORD_W-1 is 1, bits [CNT_W+ROW_AW:CNT_W+1] hold the row index, bits [CNT_W:1] hold the state count, and bit 0 holds the overflow flag.
- R4: A state word has bit WORD_W-1 equal to 0. Bits [LEN_W+COL_W-1:LEN_W] hold the start column, and bits [LEN_W-1:0] hold the run length minus one.
- R5: A run of adjacent fired pixels becomes consecutive states of MAX_RUN pixels each, taken from its first column, with the remainder in the last state. A run ends at a bank edge, that is, at a column that is a multiple of BANK_W.
- R6: States leave in ascending start column order, which is also ascending bank order.
- R7: No more than BANK_LIM states are kept from one bank. Later states in that bank are dropped.
- R8: No more than ROW_LIM states are kept per row. States after the limit is reached are dropped.
- R9: The header overflow flag is 1 exactly when at least one state of the row was dropped.
- R10: The header state count equals the number of state words that follow it. The count is at least 1 and at most ROW_LIM.
- R11: While out_valid is 1 and out_ready is 0, out_data holds its value. in_ready stays 0 until the last word of the row has been handed off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Row offered |
| in_ready | output | 1 | Encoder can take a row |
| in_row | input | ROW_AW | Row index of the offered row |
| in_pix | input | ROW_W | Discriminator bits, column 0 at bit 0 |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | WORD_W | Header or state word |

## Verification
The bench builds the encoder with a 12-pixel row, two banks of 6 columns, runs of at most 4 pixels, 2 states per bank, 3 states per row and 4 row indices. At this size every one of the 4096 row patterns can be sent in turn. The sweep therefore covers runs long enough to be split, runs cut at the bank edge, banks that hit their cap, rows that hit the row cap, and both caps at once. A repeating out_ready gap stalls header and state words alike.

// File: rtl/zs_pkg.sv
package zs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_HDR  = 2'd2,
        PH_BODY = 2'd3
    } zs_phase_e;

    localparam logic TAG_HDR   = 1'b1;
    localparam logic TAG_STATE = 1'b0;

endpackage

// File: rtl/zs_run_tracker.sv
module zs_run_tracker #(
    parameter int COL_W    = 11,
    parameter int LEN_W    = 2,
    parameter int MAX_RUN  = 4,
    parameter int BANK_LIM = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             pix,
    input  logic [COL_W-1:0] col,
    input  logic             bank_first,
    input  logic             row_full,
    output logic             push,
    output logic [COL_W-1:0] push_col,
    output logic [LEN_W-1:0] push_len,
    output logic             drop
);

    localparam int BC_W = $clog2(BANK_LIM + 1);

    typedef struct packed {
        logic             act;
        logic [COL_W-1:0] start;
        logic [LEN_W-1:0] len;
        logic [BC_W-1:0]  bcnt;
    } trk_t;

    trk_t q, d;
    logic close, room;

    always_comb begin
        // a run closes on a 0 pixel, when it is full, or at a bank edge
        close = step && q.act &&
                (!pix || (q.len == LEN_W'(MAX_RUN - 1)) || bank_first);
        room  = q.bcnt < BC_W'(BANK_LIM);
        push  = close && room && !row_full;
        drop  = close && !push;
        push_col = q.start;
        push_len = q.len;

        d = q;
        if (clear) begin
            d = '0;
        end else if (step) begin
            // the state that closes here belongs to the previous bank
            d.bcnt = bank_first ? '0 : q.bcnt + BC_W'(push);
            if (pix && (!q.act || close)) begin
                d.act   = 1'b1;
                d.start = col;
                d.len   = '0;
            end else if (pix) begin
                d.len = q.len + 1'b1;
            end else begin
                d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/zs_state_store.sv
module zs_state_store #(
    parameter int DEPTH = 9,
    parameter int DW    = 13,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [CNT_W-1:0]         cnt;
    } store_t;

    store_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (push && (q.cnt < CNT_W'(DEPTH))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (q.cnt == CNT_W'(i)) d.mem[i] = wdata;
            end
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == CNT_W'(i)) rd_data = q.mem[i];
        end
        count = q.cnt;
        full  = (q.cnt == CNT_W'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/zs_row_encoder.sv
module zs_row_encoder #(
    parameter int ROW_W    = 1152,
    parameter int BANK_W   = 64,
    parameter int ROW_NUM  = 576,
    parameter int MAX_RUN  = 4,
    parameter int BANK_LIM = 6,
    parameter int ROW_LIM  = 9,
    localparam int ROW_AW  = $clog2(ROW_NUM),
    localparam int COL_W   = $clog2(ROW_W + 1),
    localparam int LEN_W   = $clog2(MAX_RUN),
    localparam int CNT_W   = $clog2(ROW_LIM + 1),
    localparam int HDR_W   = ROW_AW + CNT_W + 1,
    localparam int ST_W    = COL_W + LEN_W,
    localparam int PAY_W   = (HDR_W > ST_W) ? HDR_W : ST_W,
    localparam int WORD_W  = PAY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ROW_AW-1:0] in_row,
    input  logic [ROW_W-1:0]  in_pix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    import zs_pkg::*;

    localparam int BP_W = (BANK_W > 1) ? $clog2(BANK_W) : 1;

    typedef struct packed {
        zs_phase_e         phase;
        logic [ROW_AW-1:0] row;
        logic [ROW_W-1:0]  pix;
        logic [COL_W-1:0]  col;
        logic [BP_W-1:0]   bpos;
        logic              hit;
        logic              ovf;
        logic [CNT_W-1:0]  rdi;
    } enc_t;

    enc_t q, d;

    logic             accept, step, pixel, bank_first, flush;
    logic             push, drop, row_full;
    logic [COL_W-1:0] push_col;
    logic [LEN_W-1:0] push_len;
    logic [ST_W-1:0]  rd_data;
    logic [CNT_W-1:0] st_cnt;

    always_comb begin
        accept     = (q.phase == PH_IDLE) && in_valid;
        step       = (q.phase == PH_SCAN);
        pixel      = q.pix[0];
        bank_first = (q.bpos == '0);
        flush      = (q.col == COL_W'(ROW_W));
    end

    zs_run_tracker #(
        .COL_W   (COL_W),
        .LEN_W   (LEN_W),
        .MAX_RUN (MAX_RUN),
        .BANK_LIM(BANK_LIM)
    ) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (step),
        .pix       (pixel),
        .col       (q.col),
        .bank_first(bank_first),
        .row_full  (row_full),
        .push      (push),
        .push_col  (push_col),
        .push_len  (push_len),
        .drop      (drop)
    );

    zs_state_store #(
        .DEPTH(ROW_LIM),
        .DW   (ST_W),
        .CNT_W(CNT_W)
    ) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .push   (push),
        .wdata  ({push_col, push_len}),
        .rd_idx (q.rdi),
        .rd_data(rd_data),
        .count  (st_cnt),
        .full   (row_full)
    );

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    d.phase = PH_SCAN;
                    d.row   = in_row;
                    d.pix   = in_pix;
                    d.col   = '0;
                    d.bpos  = '0;
                    d.hit   = 1'b0;
                    d.ovf   = 1'b0;
                    d.rdi   = '0;
                end
            end
            PH_SCAN: begin
                // zeros shift in, so the flush column reads as empty
                d.pix  = q.pix >> 1;
                d.col  = q.col + 1'b1;
                d.bpos = (q.bpos == BP_W'(BANK_W - 1)) ? '0 : q.bpos + 1'b1;
                d.hit  = q.hit | pixel;
                d.ovf  = q.ovf | drop;
                if (flush) d.phase = q.hit ? PH_HDR : PH_IDLE;
            end
            PH_HDR: begin
                if (out_ready) begin
                    d.rdi   = '0;
                    d.phase = (st_cnt == '0) ? PH_IDLE : PH_BODY;
                end
            end
            PH_BODY: begin
                if (out_ready) begin
                    if (q.rdi == st_cnt - 1'b1) d.phase = PH_IDLE;
                    else                        d.rdi   = q.rdi + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = (q.phase == PH_IDLE);
        out_valid = (q.phase == PH_HDR) || (q.phase == PH_BODY);
        out_data  = '0;
        if (q.phase == PH_HDR) begin
            out_data[WORD_W-1]               = TAG_HDR;
            out_data[CNT_W+ROW_AW:CNT_W+1]   = q.row;
            out_data[CNT_W:1]                = st_cnt;
            out_data[0]                      = q.ovf;
        end else if (q.phase == PH_BODY) begin
            out_data[WORD_W-1]  = TAG_STATE;
            out_data[ST_W-1:0]  = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/zs_row_encoder_chk.sv
module zs_row_encoder_chk #(
    parameter int ROW_W    = 1152,
    parameter int BANK_W   = 64,
    parameter int ROW_NUM  = 576,
    parameter int MAX_RUN  = 4,
    parameter int BANK_LIM = 6,
    parameter int ROW_LIM  = 9,
    localparam int ROW_AW  = $clog2(ROW_NUM),
    localparam int COL_W   = $clog2(ROW_W + 1),
    localparam int LEN_W   = $clog2(MAX_RUN),
    localparam int CNT_W   = $clog2(ROW_LIM + 1),
    localparam int HDR_W   = ROW_AW + CNT_W + 1,
    localparam int ST_W    = COL_W + LEN_W,
    localparam int PAY_W   = (HDR_W > ST_W) ? HDR_W : ST_W,
    localparam int WORD_W  = PAY_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data
);

    logic expect_hdr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      expect_hdr_q <= 1'b0;
        else if (in_valid && in_ready)   expect_hdr_q <= 1'b1;
        else if (out_valid && out_ready) expect_hdr_q <= 1'b0;
    end

    logic             is_hdr;
    logic [CNT_W-1:0] hdr_cnt;
    logic [COL_W-1:0] st_col;
    logic [LEN_W-1:0] st_len;

    always_comb begin
        is_hdr  = out_data[WORD_W-1];
        hdr_cnt = out_data[CNT_W:1];
        st_col  = out_data[LEN_W+COL_W-1:LEN_W];
        st_len  = out_data[LEN_W-1:0];
    end

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11

    AST_BUSY_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R11

    AST_HEADER_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && expect_hdr_q |-> is_hdr); // R3

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && is_hdr |-> (hdr_cnt != '0) && (hdr_cnt <= CNT_W'(ROW_LIM))); // R10

    AST_STATE_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !is_hdr |->
            (int'(st_col) < ROW_W) &&
            ((int'(st_col) % BANK_W) + int'(st_len) < BANK_W)); // R5

endmodule

bind zs_row_encoder zs_row_encoder_chk #(
    .ROW_W   (ROW_W),
    .BANK_W  (BANK_W),
    .ROW_NUM (ROW_NUM),
    .MAX_RUN (MAX_RUN),
    .BANK_LIM(BANK_LIM),
    .ROW_LIM (ROW_LIM)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/test_zs_row_encoder.sv
module test_zs_row_encoder;

    localparam int ROW_W    = 12;
    localparam int BANK_W   = 6;
    localparam int ROW_NUM  = 4;
    localparam int MAX_RUN  = 4;
    localparam int BANK_LIM = 2;
    localparam int ROW_LIM  = 3;
    localparam int ROW_AW   = $clog2(ROW_NUM);
    localparam int COL_W    = $clog2(ROW_W + 1);
    localparam int LEN_W    = $clog2(MAX_RUN);
    localparam int CNT_W    = $clog2(ROW_LIM + 1);
    localparam int HDR_W    = ROW_AW + CNT_W + 1;
    localparam int ST_W     = COL_W + LEN_W;
    localparam int PAY_W    = (HDR_W > ST_W) ? HDR_W : ST_W;
    localparam int WORD_W   = PAY_W + 1;
    localparam int NB       = ROW_W / BANK_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ROW_AW-1:0] in_row = '0;
    logic [ROW_W-1:0]  in_pix = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [WORD_W-1:0] out_data;

    always #4 clk = ~clk;

    zs_row_encoder #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .ROW_NUM(ROW_NUM),
        .MAX_RUN(MAX_RUN), .BANK_LIM(BANK_LIM), .ROW_LIM(ROW_LIM)
    ) i_zs_row_encoder (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    int exp_n;
    bit exp_bdrop, exp_rdrop;
    int exp_col [ROW_LIM];
    int exp_len [ROW_LIM];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_expected(input logic [ROW_W-1:0] p);
        exp_n = 0; exp_bdrop = 0; exp_rdrop = 0;
        for (int b = 0; b < NB; b++) begin
            int kept = 0;
            int c = 0;
            while (c < BANK_W) begin
                if (p[b*BANK_W + c]) begin
                    int s = c;
                    int l = 0;
                    while (c < BANK_W && p[b*BANK_W + c] && l < MAX_RUN) begin
                        l++; c++;
                    end
                    if (kept >= BANK_LIM)      exp_bdrop = 1;
                    else if (exp_n >= ROW_LIM) exp_rdrop = 1;
                    else begin
                        exp_col[exp_n] = b*BANK_W + s;
                        exp_len[exp_n] = l;
                        exp_n++;
                        kept++;
                    end
                end else begin
                    c++;
                end
            end
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    task automatic run_row(input logic [ROW_W-1:0] p, input int row);
        int  got_hdr = 0;
        int  got_st  = 0;
        bit  stall   = 0;
        logic [WORD_W-1:0] held = '0;
        bit  hit = (p != '0);
        build_expected(p);
        @(negedge clk);
        in_valid = 1'b1; in_pix = p; in_row = ROW_AW'(row);
        @(negedge clk);
        in_valid = 1'b0;
        forever begin
            out_ready = ((cyc % 5) != 2);
            if (stall) begin
                check(out_valid && (out_data == held), "R11 hold", int'(out_data), int'(held));
            end
            if (out_valid) begin
                check(!in_ready, "R11 busy", int'(in_ready), 0);
                stall = !out_ready;
                held  = out_data;
                if (out_ready) begin
                    if (got_hdr == 0) begin
                        got_hdr = 1;
                        check(out_data[WORD_W-1] == 1'b1 &&
                              int'(out_data[CNT_W+ROW_AW:CNT_W+1]) == row,
                              "R3 header", int'(out_data), row);
                        check(int'(out_data[CNT_W:1]) == exp_n, "R10 count",
                              int'(out_data[CNT_W:1]), exp_n);
                        check(out_data[0] == (exp_bdrop | exp_rdrop), "R9 overflow",
                              int'(out_data[0]), int'(exp_bdrop | exp_rdrop));
                    end else begin
                        int ew = (got_st < exp_n) ?
                                 ((exp_col[got_st] << LEN_W) | (exp_len[got_st] - 1)) : -1;
                        check(int'(out_data) == ew, "R4 R5 R6 state", int'(out_data), ew);
                        got_st++;
                    end
                end
            end else begin
                stall = 0;
                if (in_ready) break;
            end
            @(negedge clk);
        end
        if (!hit) begin
            check(got_hdr == 0 && got_st == 0, "R2 empty row", got_hdr + got_st, 0);
        end else begin
            string tag = exp_bdrop ? "R7 bank cap" : (exp_rdrop ? "R8 row cap" : "R10 states");
            check(got_hdr == 1 && got_st == exp_n, tag, got_st, exp_n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R1 in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1 out_valid", int'(out_valid), 0);
        check(in_ready, "R1 in_ready", int'(in_ready), 1);
        for (int p = 0; p < (1 << ROW_W); p++) begin
            run_row(ROW_W'(p), p % ROW_NUM);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule